// File: doc/BRIEF.md
# Packet-Filter VM Integer Execution Unit

This block is the integer arithmetic stage of a small packet-filter virtual machine. Each cycle it can take one instruction's opcode byte, the current value of the destination register, the value of the source register and the 32-bit immediate. It produces the 64-bit value to write back to the destination register, registered one cycle later. The register file and the program counter are outside this block.

The opcode byte carries three fields. The upper nibble names the operation. One bit chooses the second operand: the immediate or the source register. The low three bits give the instruction class, and this class picks 32-bit or 64-bit semantics. The same operation space also holds a byte-order conversion. For that instruction the source bit gives the direction and the immediate gives the width in bits. Classes that are not arithmetic, and codes that are not defined, pass the destination value through unchanged. A register-file write stage can therefore take the result of every instruction without extra decoding.

Top module: `vm_int_alu`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by one clock. `result` loads the computed value one clock after a cycle with `in_valid` high and holds its value otherwise. Reset clears both to zero.
- R2: The opcode byte is decoded as follows: bits 7:4 are the operation, bit 3 is the source select, and bits 2:0 are the class. Class 3'b111 gives 64-bit semantics and class 3'b100 gives 32-bit semantics.
- R3: Source select 0 uses the immediate, sign-extended from bit 31, as the second operand. Source select 1 uses `src_val`.
- R4: The codes are add 0x0, subtract 0x1, multiply 0x2, OR 0x4, AND 0x5, XOR 0xA and move 0xB. Each wraps modulo the class width, and multiply keeps the low half of the product.
- R5: Every 32-bit class result other than byte-order conversion uses only the low 32 bits of the operands and is zero-extended to 64 bits.
- R6: Left shift (0x6) and logical right shift (0x7) take the shift amount from the second operand. The amount is masked to 5 bits in the 32-bit class and to 6 bits in the 64-bit class.
- R7: Arithmetic right shift (0xC) fills with the sign bit of the class width: bit 31 in the 32-bit class and bit 63 in the 64-bit class.
- R8: Negate (0x8) returns the two's complement of the destination at the class width and ignores both the source register and the immediate.
- R9: Divide (0x3) is unsigned. A zero divisor gives 0.
- R10: Modulo (0x9) is unsigned. A zero divisor returns the destination at the class width (in the 32-bit class, its low 32 bits zero-extended).
- R11: Byte-order conversion (0xD, 32-bit class) with source bit 0 keeps the low 16, 32 or 64 bits of the destination, chosen by immediate value 16, 32 or 64, and clears the bits above.
- R12: Byte-order conversion with source bit 1 reverses the byte order of the low 16, 32 or 64 bits and clears the bits above.
- R13: Classes other than 3'b100 and 3'b111, codes 0xE and 0xF, code 0xD in the 64-bit class, and byte-order conversion with any other immediate all return `dst_val` unchanged in all 64 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| opcode | input | 8 | Operation, source select and class |
| dst_val | input | 64 | Current destination register value |
| src_val | input | 64 | Source register value |
| imm | input | 32 | Immediate field, sign-extended inside |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| result | output | 64 | Value to write back to the destination |

## Verification
The cases hardest to reach from the ports are the narrow corners of the operand space: zero divisors, shift amounts of 32 or more that must be masked, sign bits sitting exactly at bit 31 or bit 63, and byte-order conversion with an immediate other than 16, 32 or 64. Uniform random operands almost never produce these values. The stimulus therefore draws each operand from a biased pool that includes zero, one, all ones, the two sign-bit patterns and small values. It also draws the class from both arithmetic classes, with occasional foreign classes mixed in. Directed cases then pin every such corner explicitly.

// File: rtl/vm_alu_pkg.sv
package vm_alu_pkg;

    localparam int VM_XLEN = 64;
    localparam int VM_IMMW = 32;

    localparam logic [2:0] CLS_ALU32 = 3'b100;
    localparam logic [2:0] CLS_ALU64 = 3'b111;

    typedef enum logic [3:0] {
        OP_ADD  = 4'h0,
        OP_SUB  = 4'h1,
        OP_MUL  = 4'h2,
        OP_DIV  = 4'h3,
        OP_OR   = 4'h4,
        OP_AND  = 4'h5,
        OP_LSH  = 4'h6,
        OP_RSH  = 4'h7,
        OP_NEG  = 4'h8,
        OP_MOD  = 4'h9,
        OP_XOR  = 4'hA,
        OP_MOV  = 4'hB,
        OP_ARSH = 4'hC,
        OP_END  = 4'hD
    } alu_op_e;

    typedef struct packed {
        logic               vld;
        logic [VM_XLEN-1:0] res;
    } alu_state_t;

endpackage

// File: rtl/vm_alu_operands.sv
module vm_alu_operands #(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 32
) (
    input  logic              is_w32,
    input  logic              use_reg,
    input  logic [DATA_W-1:0] dst_val,
    input  logic [DATA_W-1:0] src_val,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] op_a,
    output logic [DATA_W-1:0] op_a_sx,
    output logic [DATA_W-1:0] op_b,
    output logic [$clog2(DATA_W)-1:0] sh_amt
);
    localparam int HALF_W = DATA_W / 2;
    localparam int SH_W   = $clog2(DATA_W);

    logic [DATA_W-1:0] imm_sx;
    logic [DATA_W-1:0] b_full;

    always_comb begin
        imm_sx = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
        b_full = use_reg ? src_val : imm_sx;
        if (is_w32) begin
            op_a    = {{HALF_W{1'b0}}, dst_val[HALF_W-1:0]};
            op_a_sx = {{HALF_W{dst_val[HALF_W-1]}}, dst_val[HALF_W-1:0]};
            op_b    = {{HALF_W{1'b0}}, b_full[HALF_W-1:0]};
            sh_amt  = {1'b0, b_full[SH_W-2:0]};
        end else begin
            op_a    = dst_val;
            op_a_sx = dst_val;
            op_b    = b_full;
            sh_amt  = b_full[SH_W-1:0];
        end
    end
endmodule

// File: rtl/vm_alu_shifter.sv
module vm_alu_shifter #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0]         val_zx,
    input  logic [DATA_W-1:0]         val_sx,
    input  logic [$clog2(DATA_W)-1:0] amt,
    output logic [DATA_W-1:0]         shl,
    output logic [DATA_W-1:0]         shr,
    output logic [DATA_W-1:0]         sar
);
    always_comb begin
        shl = val_zx << amt;
        shr = val_zx >> amt;
        sar = $unsigned($signed(val_sx) >>> amt);
    end
endmodule

// File: rtl/vm_alu_divmod.sv
module vm_alu_divmod #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] num,
    input  logic [DATA_W-1:0] den,
    output logic [DATA_W-1:0] quo,
    output logic [DATA_W-1:0] rem
);
    logic den_zero;

    always_comb begin
        den_zero = (den == '0);
        if (den_zero) begin
            quo = '0;
            rem = num;
        end else begin
            quo = num / den;
            rem = num % den;
        end
    end
endmodule

// File: rtl/vm_alu_byteorder.sv
module vm_alu_byteorder #(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 32
) (
    input  logic [DATA_W-1:0] val,
    input  logic              to_big,
    input  logic [IMM_W-1:0]  width_sel,
    output logic [DATA_W-1:0] conv,
    output logic              width_ok
);
    localparam int NB_FULL = DATA_W / 8;
    localparam int NB_HALF = NB_FULL / 2;
    localparam int NB_QTR  = NB_FULL / 4;

    logic [DATA_W-1:0]   rev_full;
    logic [DATA_W/2-1:0] rev_half;
    logic [DATA_W/4-1:0] rev_qtr;

    genvar g;
    generate
        for (g = 0; g < NB_FULL; g++) begin : g_rev_full
            assign rev_full[8*g +: 8] = val[8*(NB_FULL-1-g) +: 8];
        end
        for (g = 0; g < NB_HALF; g++) begin : g_rev_half
            assign rev_half[8*g +: 8] = val[8*(NB_HALF-1-g) +: 8];
        end
        for (g = 0; g < NB_QTR; g++) begin : g_rev_qtr
            assign rev_qtr[8*g +: 8] = val[8*(NB_QTR-1-g) +: 8];
        end
    endgenerate

    always_comb begin
        width_ok = 1'b1;
        conv     = val;
        if (width_sel == IMM_W'(DATA_W/4)) begin
            conv = to_big ? {{(DATA_W*3/4){1'b0}}, rev_qtr}
                          : {{(DATA_W*3/4){1'b0}}, val[DATA_W/4-1:0]};
        end else if (width_sel == IMM_W'(DATA_W/2)) begin
            conv = to_big ? {{(DATA_W/2){1'b0}}, rev_half}
                          : {{(DATA_W/2){1'b0}}, val[DATA_W/2-1:0]};
        end else if (width_sel == IMM_W'(DATA_W)) begin
            conv = to_big ? rev_full : val;
        end else begin
            width_ok = 1'b0;
        end
    end
endmodule

// File: rtl/vm_int_alu.sv
module vm_int_alu
    import vm_alu_pkg::*;
#(
    parameter int DATA_W = VM_XLEN,
    parameter int IMM_W  = VM_IMMW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        opcode,
    input  logic [DATA_W-1:0] dst_val,
    input  logic [DATA_W-1:0] src_val,
    input  logic [IMM_W-1:0]  imm,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);
    localparam int HALF_W = DATA_W / 2;
    localparam int SH_W   = $clog2(DATA_W);

    logic [3:0] op_code;
    logic       use_reg;
    logic [2:0] op_cls;
    logic       is_w32;
    logic       is_alu;

    assign op_code = opcode[7:4];
    assign use_reg = opcode[3];
    assign op_cls  = opcode[2:0];
    assign is_w32  = (op_cls == CLS_ALU32);
    assign is_alu  = (op_cls == CLS_ALU32) || (op_cls == CLS_ALU64);

    logic [DATA_W-1:0] op_a, op_a_sx, op_b;
    logic [SH_W-1:0]   sh_amt;
    logic [DATA_W-1:0] shl_v, shr_v, sar_v;
    logic [DATA_W-1:0] quo_v, rem_v;
    logic [DATA_W-1:0] end_v;
    logic              end_ok;

    vm_alu_operands #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_operands (
        .is_w32  (is_w32),
        .use_reg (use_reg),
        .dst_val (dst_val),
        .src_val (src_val),
        .imm     (imm),
        .op_a    (op_a),
        .op_a_sx (op_a_sx),
        .op_b    (op_b),
        .sh_amt  (sh_amt)
    );

    vm_alu_shifter #(.DATA_W(DATA_W)) u_shifter (
        .val_zx (op_a),
        .val_sx (op_a_sx),
        .amt    (sh_amt),
        .shl    (shl_v),
        .shr    (shr_v),
        .sar    (sar_v)
    );

    vm_alu_divmod #(.DATA_W(DATA_W)) u_divmod (
        .num (op_a),
        .den (op_b),
        .quo (quo_v),
        .rem (rem_v)
    );

    vm_alu_byteorder #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_byteorder (
        .val       (dst_val),
        .to_big    (use_reg),
        .width_sel (imm),
        .conv      (end_v),
        .width_ok  (end_ok)
    );

    alu_state_t        state_d, state_q;
    logic [DATA_W-1:0] raw_v;
    logic [DATA_W-1:0] fin_v;
    logic              narrow_ok;

    always_comb begin
        raw_v     = dst_val;
        narrow_ok = 1'b1;
        case (op_code)
            OP_ADD:  raw_v = op_a + op_b;
            OP_SUB:  raw_v = op_a - op_b;
            OP_MUL:  raw_v = op_a * op_b;
            OP_DIV:  raw_v = quo_v;
            OP_OR:   raw_v = op_a | op_b;
            OP_AND:  raw_v = op_a & op_b;
            OP_LSH:  raw_v = shl_v;
            OP_RSH:  raw_v = shr_v;
            OP_NEG:  raw_v = '0 - op_a;
            OP_MOD:  raw_v = rem_v;
            OP_XOR:  raw_v = op_a ^ op_b;
            OP_MOV:  raw_v = op_b;
            OP_ARSH: raw_v = sar_v;
            OP_END: begin
                narrow_ok = 1'b0;
                raw_v     = (is_w32 && end_ok) ? end_v : dst_val;
            end
            default: begin
                narrow_ok = 1'b0;
                raw_v     = dst_val;
            end
        endcase

        if (!is_alu) begin
            fin_v = dst_val;
        end else if (is_w32 && narrow_ok) begin
            fin_v = {{HALF_W{1'b0}}, raw_v[HALF_W-1:0]};
        end else begin
            fin_v = raw_v;
        end

        state_d     = state_q;
        state_d.vld = in_valid;
        if (in_valid) begin
            state_d.res = fin_v;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.vld;
    assign result    = state_q.res;

    // R1: valid timing and hold
    p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result)));

    // R5: 32-bit class results zero-extended
    p_zext_w32_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode[2:0] == CLS_ALU32 && opcode[7:4] < 4'hD)
        |=> (result[DATA_W-1:HALF_W] == '0));

    // R8: 64-bit negate of destination
    p_neg64_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode[2:0] == CLS_ALU64 && opcode[7:4] == OP_NEG)
        |=> (result == ('0 - $past(dst_val))));

    // R9: 64-bit register divide by zero
    p_div_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == {OP_DIV, 1'b1, CLS_ALU64} && src_val == '0)
        |=> (result == '0));

    // R11: little-endian 16-bit conversion clears upper bits
    p_le16_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == {OP_END, 1'b0, CLS_ALU32} && imm == IMM_W'(16))
        |=> (result[DATA_W-1:16] == '0 && result[15:0] == $past(dst_val[15:0])));

    // R13: foreign classes pass the destination through
    p_passthru_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode[2:0] != CLS_ALU32 && opcode[2:0] != CLS_ALU64)
        |=> (result == $past(dst_val)));

endmodule

// File: tb/vm_int_alu_tb.sv
`timescale 1ns/1ps
module vm_int_alu_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  opcode = '0;
    logic [63:0] dst_val = '0;
    logic [63:0] src_val = '0;
    logic [31:0] imm = '0;
    logic        out_valid;
    logic [63:0] result;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    vm_int_alu u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .opcode    (opcode),
        .dst_val   (dst_val),
        .src_val   (src_val),
        .imm       (imm),
        .out_valid (out_valid),
        .result    (result)
    );

    function automatic logic [63:0] ref_alu(input logic [7:0] opc, input logic [63:0] d,
                                            input logic [63:0] s, input logic [31:0] im);
        logic [2:0]  cls;
        logic [3:0]  code;
        logic [63:0] b;
        logic [31:0] x, y, r32;
        int          w;
        logic [63:0] r;
        cls  = opc[2:0];
        code = opc[7:4];
        b    = opc[3] ? s : {{32{im[31]}}, im};
        if (cls == 3'b111) begin
            case (code)
                4'h0: return d + b;
                4'h1: return d - b;
                4'h2: return d * b;
                4'h3: return (b == 0) ? 64'd0 : d / b;
                4'h4: return d | b;
                4'h5: return d & b;
                4'h6: return d << b[5:0];
                4'h7: return d >> b[5:0];
                4'h8: return -d;
                4'h9: return (b == 0) ? d : d % b;
                4'hA: return d ^ b;
                4'hB: return b;
                4'hC: return $unsigned($signed(d) >>> b[5:0]);
                default: return d;
            endcase
        end else if (cls == 3'b100) begin
            x = d[31:0];
            y = b[31:0];
            if (code == 4'hD) begin
                if (im != 16 && im != 32 && im != 64) return d;
                w = int'(im);
                r = '0;
                for (int i = 0; i < w / 8; i++) begin
                    if (opc[3]) r[8*i +: 8] = d[8*(w/8-1-i) +: 8];
                    else        r[8*i +: 8] = d[8*i +: 8];
                end
                return r;
            end
            case (code)
                4'h0: r32 = x + y;
                4'h1: r32 = x - y;
                4'h2: r32 = x * y;
                4'h3: r32 = (y == 0) ? 32'd0 : x / y;
                4'h4: r32 = x | y;
                4'h5: r32 = x & y;
                4'h6: r32 = x << y[4:0];
                4'h7: r32 = x >> y[4:0];
                4'h8: r32 = -x;
                4'h9: r32 = (y == 0) ? x : x % y;
                4'hA: r32 = x ^ y;
                4'hB: r32 = y;
                4'hC: r32 = $unsigned($signed(x) >>> y[4:0]);
                default: return d;
            endcase
            return {32'd0, r32};
        end
        return d;
    endfunction

    function automatic string req_for(input logic [7:0] opc);
        if (opc[2:0] != 3'b100 && opc[2:0] != 3'b111) return "R13";
        case (opc[7:4])
            4'h3: return "R9";
            4'h6, 4'h7: return "R6";
            4'h8: return "R8";
            4'h9: return "R10";
            4'hC: return "R7";
            4'hD: return (opc[2:0] != 3'b100) ? "R13" : (opc[3] ? "R12" : "R11");
            4'hE, 4'hF: return "R13";
            default: return "R4";
        endcase
    endfunction

    function automatic logic [63:0] pick64();
        case ($urandom % 8)
            0: return 64'd0;
            1: return 64'd1;
            2: return '1;
            3: return 64'h0000_0000_8000_0000;
            4: return 64'h8000_0000_0000_0000;
            5: return 64'($urandom % 70);
            default: return {$urandom, $urandom};
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [7:0] opc, input logic [63:0] d, input logic [63:0] s,
                          input logic [31:0] im, input string tag);
        logic [63:0] exp;
        exp = ref_alu(opc, d, s, im);
        @(negedge clk);
        opcode   = opc;
        dst_val  = d;
        src_val  = s;
        imm      = im;
        in_valid = 1'b1;
        @(negedge clk);
        check({tag, " out_valid"}, {63'd0, out_valid}, 64'd1);
        check(tag, result, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog: actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] held;
        logic [7:0]  ropc;
        logic [31:0] rimm;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 reset out_valid", {63'd0, out_valid}, 64'd0);
        check("R1 reset result", result, 64'd0);

        // R2 class selects width
        run_op(8'h17, 64'd0, 64'd0, 32'd1, "R2 sub64");
        run_op(8'h14, 64'd0, 64'd0, 32'd1, "R2 sub32");
        // R3 source select
        run_op(8'h07, 64'd10, 64'd999, 32'hFFFF_FFFD, "R3 imm sign-extended");
        run_op(8'h0F, 64'd1, 64'd5, 32'd100, "R3 register source");
        // R4 multiply low half
        run_op(8'h2F, 64'h1_0000_0001, 64'h1_0000_0001, 32'd0, "R4 mul64");
        // R5 zero extension
        run_op(8'h04, '1, 64'd0, 32'd1, "R5 add32 wrap");
        run_op(8'h0C, 64'h1234_5678_0000_0001, 64'hFFFF_0000_0000_0002, 32'd0, "R5 add32 reg");
        // R6 shift masking
        run_op(8'h67, 64'd1, 64'd0, 32'd65, "R6 lsh64 mask");
        run_op(8'h64, 64'd1, 64'd0, 32'd33, "R6 lsh32 mask");
        run_op(8'h77, '1, 64'd0, 32'd63, "R6 rsh64");
        // R7 arithmetic shift sign
        run_op(8'hC4, 64'h0000_0000_8000_0000, 64'd0, 32'd4, "R7 arsh32");
        run_op(8'hC7, 64'h8000_0000_0000_0000, 64'd0, 32'd63, "R7 arsh64");
        // R8 negate ignores source
        run_op(8'h8F, 64'd5, 64'd99, 32'd7, "R8 neg64");
        run_op(8'h84, 64'hAAAA_0000_0000_0001, 64'd3, 32'd9, "R8 neg32");
        // R9 divide
        run_op(8'h3F, 64'd77, 64'd0, 32'd5, "R9 div by zero");
        run_op(8'h37, 64'd100, 64'd0, 32'd7, "R9 div64");
        // R10 modulo
        run_op(8'h9F, 64'd77, 64'd0, 32'd5, "R10 mod64 by zero");
        run_op(8'h94, 64'hAAAA_BBBB_0000_0005, 64'd0, 32'd0, "R10 mod32 by zero");
        // R11 little-endian conversion
        run_op(8'hD4, 64'h1122_3344_5566_7788, 64'd0, 32'd16, "R11 le16");
        run_op(8'hD4, 64'h1122_3344_5566_7788, 64'd0, 32'd32, "R11 le32");
        run_op(8'hD4, 64'h1122_3344_5566_7788, 64'd0, 32'd64, "R11 le64");
        // R12 big-endian conversion
        run_op(8'hDC, 64'h1122_3344_5566_7788, 64'd0, 32'd16, "R12 be16");
        run_op(8'hDC, 64'h1122_3344_5566_7788, 64'd0, 32'd32, "R12 be32");
        run_op(8'hDC, 64'h1122_3344_5566_7788, 64'd0, 32'd64, "R12 be64");
        // R13 pass-through cases
        run_op(8'hDC, 64'h1122_3344_5566_7788, 64'd0, 32'd8, "R13 bad width");
        run_op(8'hD7, 64'h1122_3344_5566_7788, 64'd0, 32'd16, "R13 end in 64 class");
        run_op(8'h05, 64'hDEAD_BEEF_0000_1234, 64'd1, 32'd1, "R13 foreign class");
        run_op(8'hE4, 64'hDEAD_BEEF_0000_1234, 64'd1, 32'd1, "R13 undefined code");

        // R1 idle hold
        @(negedge clk);
        held     = result;
        in_valid = 1'b0;
        opcode   = 8'h0F;
        dst_val  = 64'h5555;
        src_val  = 64'h7777;
        @(negedge clk);
        check("R1 idle out_valid", {63'd0, out_valid}, 64'd0);
        check("R1 idle result hold", result, held);

        // random mix
        for (int k = 0; k < 3000; k++) begin
            ropc[7:4] = 4'($urandom % 16);
            ropc[3]   = 1'($urandom % 2);
            case ($urandom % 8)
                0: ropc[2:0] = 3'($urandom % 8);
                1, 2, 3: ropc[2:0] = 3'b100;
                default: ropc[2:0] = 3'b111;
            endcase
            case ($urandom % 4)
                0: rimm = 32'd16 << ($urandom % 3);
                1: rimm = 32'($urandom % 70);
                default: rimm = $urandom;
            endcase
            run_op(ropc, pick64(), pick64(), rimm, req_for(ropc));
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule